// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block walks one channel's ring of buffer descriptors kept in a word-addressed descriptor RAM. Each descriptor takes three consecutive 32-bit words: a control word holding a byte count, a status byte and a command byte, then the buffer address, then an extended address that the walker does not use. A start pulse loads the ring base pointer. From then on the walker fetches the control word and, if the descriptor belongs to the engine, the buffer address. It then asks an external data mover for one transfer of the given byte count and access width. When the mover reports completion, the walker writes the updated control word back and moves on.

Ownership passes through the done bit of the status byte. The walker hands a descriptor back by clearing that bit on writeback, and it stops at the first descriptor that it does not own. Other status bits decide what happens next: the walker can return to the ring base, stop after the current descriptor, or raise a one-cycle interrupt for that descriptor. A descriptor whose width and alignment do not agree, or whose command is not a known width code, is returned with its error bit set and no transfer is made. A transfer that the mover reports as failed is also returned with its error bit set.

Top module: `bd_ring_walker`

## Requirements
- R1: After reset the walker is idle (`idle_o`=1) and drives no memory access, no transfer request and no interrupt.
- R2: A `start_i` pulse taken while idle makes the next memory access a read of word address `base_ptr_i`, so the walk begins at the ring base.
- R3: Control word layout: byte count in bits 15:0, status in bits 23:16, command in bits 31:24. The transfer request carries the count, the buffer address from word 1, and a size code. Command 0 gives size 2 (4-byte words), command 2 gives size 1 (2-byte words) and command 1 gives size 0 (single bytes).
- R4: Status bit 0 (done) set means the engine owns the descriptor. If it is clear, the walker goes idle without a transfer or a write.
- R5: On completion the control word is written back with the done bit cleared. The count, the command and every other status bit are kept, apart from the error bit of R9 and R10.
- R6: If status bit 1 (wrap) is set, the next fetch is at the ring base. Otherwise it is three words further on.
- R7: If status bit 2 (continue) is clear, the walker goes idle after writing that descriptor back.
- R8: If status bit 3 (interrupt) is set, `irq_o` pulses for exactly one cycle after that descriptor is written back. No pulse occurs for a descriptor without this bit.
- R9: If the mover completes with `xfer_err_i`=1, status bit 4 (error) is set on writeback.
- R10: The error bit is set and no transfer is requested in three cases: a 4-byte-width descriptor whose count or address is not a multiple of 4, a 2-byte-width descriptor whose count or address is odd, and a command byte other than 0, 1 or 2.
- R11: A `start_i` pulse while the walker is busy has no effect.
- R12: Once raised, `xfer_req_o` stays high with stable address, count and size until `xfer_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_ptr_i | input | AW | Word address of the first descriptor of the ring |
| mem_req_o | output | 1 | Descriptor RAM access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Descriptor RAM word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read access |
| xfer_req_o | output | 1 | Transfer request to the data mover |
| xfer_addr_o | output | 32 | Buffer address of the transfer |
| xfer_count_o | output | 16 | Byte count of the transfer |
| xfer_size_o | output | 2 | Access size code: 2 = 4 bytes, 1 = 2 bytes, 0 = 1 byte |
| xfer_done_i | input | 1 | Data mover completion, one cycle |
| xfer_err_i | input | 1 | Transfer failed, sampled with `xfer_done_i` |
| irq_o | output | 1 | One-cycle completion interrupt |
| idle_o | output | 1 | Walker idle |

## Verification
The main walk is run on a ring of three owned descriptors, one of each width, with the last one carrying wrap. A decoy owned descriptor sits just past the ring, so a missing wrap shows up as an extra transfer, and the unowned descriptor at the base after the wrap proves that the walk stops there. A second ring has the continue bit clear on an owned descriptor followed by another owned one, which separates a stop after the current descriptor from an ownership stop. A third ring mixes a mover failure, a misaligned word descriptor, an odd half-word address and an unknown command, which separates the reported error from the locally detected ones and shows that no request is issued for the latter. Two short runs cover a start on an unowned descriptor and a second start pulse given while a transfer is pending.

// File: rtl/bdw_pkg.sv
package bdw_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  localparam int DESC_WORDS = 3;

  // status byte bit positions (bits 23:16 of the control word)
  localparam int ST_DONE = 0;
  localparam int ST_WRAP = 1;
  localparam int ST_CONT = 2;
  localparam int ST_IRQ  = 3;
  localparam int ST_ERR  = 4;

  // command byte width codes
  localparam logic [7:0] CMD_W32 = 8'd0;
  localparam logic [7:0] CMD_W8  = 8'd1;
  localparam logic [7:0] CMD_W16 = 8'd2;

  typedef enum logic [2:0] {
    WK_IDLE, WK_RD0, WK_RD1, WK_CHK, WK_XFER, WK_WB
  } walk_state_e;
endpackage

// File: rtl/bdw_width_chk.sv
module bdw_width_chk
  import bdw_pkg::*;
(
  input  logic [7:0]        cmd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              ok_o,
  output logic [1:0]        size_o
);
  always_comb begin
    ok_o   = 1'b0;
    size_o = 2'd0;
    unique case (cmd_i)
      CMD_W32: begin
        size_o = 2'd2;
        ok_o   = (count_i[1:0] == 2'b00) && (addr_i[1:0] == 2'b00);
      end
      CMD_W16: begin
        size_o = 2'd1;
        ok_o   = !count_i[0] && !addr_i[0];
      end
      CMD_W8: begin
        size_o = 2'd0;
        ok_o   = 1'b1;
      end
      default: begin
        size_o = 2'd0;
        ok_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bdw_ptr_unit.sv
module bdw_ptr_unit
  import bdw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

  logic [AW-1:0] base_q, base_d, ptr_q, ptr_d;
  logic          en;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    if (load_i) begin
      base_d = base_i;
      ptr_d  = base_i;
    end else if (adv_i) begin
      ptr_d = wrap_i ? base_q : ptr_q + STEP;
    end
  end

  assign en = load_i | adv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker
  import bdw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     base_ptr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              xfer_req_o,
  output logic [WORD_W-1:0] xfer_addr_o,
  output logic [CNT_W-1:0]  xfer_count_o,
  output logic [1:0]        xfer_size_o,
  input  logic              xfer_done_i,
  input  logic              xfer_err_i,
  output logic              irq_o,
  output logic              idle_o
);
  localparam int ST_LSB = CNT_W;
  localparam int CMD_LSB = CNT_W + 8;

  walk_state_e       state_q, state_d;
  logic [WORD_W-1:0] w0_q, w0_d, addr_q, addr_d;
  logic              err_q, err_d, irq_q, irq_d;
  logic              ptr_load, ptr_adv;
  logic [AW-1:0]     ptr;
  logic              fmt_ok;
  logic [1:0]        fmt_size;
  logic [7:0]        st_cur, st_wb;

  assign st_cur = w0_q[ST_LSB +: 8];

  always_comb begin
    st_wb = st_cur;
    st_wb[ST_DONE] = 1'b0;
    if (err_q) st_wb[ST_ERR] = 1'b1;
  end

  bdw_ptr_unit #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ptr_load),
    .base_i (base_ptr_i),
    .adv_i  (ptr_adv),
    .wrap_i (st_cur[ST_WRAP]),
    .ptr_o  (ptr)
  );

  // address is taken from the read port while in WK_CHK
  bdw_width_chk u_chk (
    .cmd_i   (w0_q[CMD_LSB +: 8]),
    .count_i (w0_q[CNT_W-1:0]),
    .addr_i  (state_q == WK_CHK ? mem_rdata_i : addr_q),
    .ok_o    (fmt_ok),
    .size_o  (fmt_size)
  );

  always_comb begin
    state_d     = state_q;
    w0_d        = w0_q;
    addr_d      = addr_q;
    err_d       = err_q;
    irq_d       = 1'b0;
    ptr_load    = 1'b0;
    ptr_adv     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = {w0_q[CMD_LSB +: 8], st_wb, w0_q[CNT_W-1:0]};
    xfer_req_o  = 1'b0;
    unique case (state_q)
      WK_IDLE: begin
        if (start_i) begin
          ptr_load = 1'b1;
          state_d  = WK_RD0;
        end
      end
      WK_RD0: begin
        mem_req_o = 1'b1;
        err_d     = 1'b0;
        state_d   = WK_RD1;
      end
      WK_RD1: begin
        w0_d = mem_rdata_i;
        if (mem_rdata_i[ST_LSB + ST_DONE]) begin
          mem_req_o  = 1'b1;
          mem_addr_o = ptr + AW'(1);
          state_d    = WK_CHK;
        end else begin
          state_d = WK_IDLE;
        end
      end
      WK_CHK: begin
        addr_d  = mem_rdata_i;
        err_d   = !fmt_ok;
        state_d = fmt_ok ? WK_XFER : WK_WB;
      end
      WK_XFER: begin
        xfer_req_o = 1'b1;
        if (xfer_done_i) begin
          err_d   = xfer_err_i;
          state_d = WK_WB;
        end
      end
      WK_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        ptr_adv   = 1'b1;
        irq_d     = st_cur[ST_IRQ];
        state_d   = st_cur[ST_CONT] ? WK_RD0 : WK_IDLE;
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      w0_q    <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
      if (state_q == WK_RD1) w0_q   <= w0_d;
      if (state_q == WK_CHK) addr_q <= addr_d;
    end
  end

  assign xfer_addr_o  = addr_q;
  assign xfer_count_o = w0_q[CNT_W-1:0];
  assign xfer_size_o  = fmt_size;
  assign irq_o        = irq_q;
  assign idle_o       = (state_q == WK_IDLE);

  // R1: nothing is driven while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!mem_req_o && !xfer_req_o));

  // R2: first access after an accepted start is at the base
  p_start_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_o) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(base_ptr_i)));

  // R4: an unowned control word ends the walk
  p_unowned_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_RD1 && !mem_rdata_i[ST_LSB + ST_DONE]) |=> idle_o);

  // R5: writeback always hands ownership back
  p_wb_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[ST_LSB + ST_DONE]);

  // R8: interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R12: request held steady until the mover answers
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_done_i) |=>
      (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_count_o) && $stable(xfer_size_o)));
endmodule

// File: tb/bd_ring_walker_tb.sv
`timescale 1ns/1ps
module bd_ring_walker_tb;
  localparam int AW = 8;

  logic          clk, rst_n, start_i;
  logic [AW-1:0] base_ptr_i;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i;
  logic          xfer_req_o;
  logic [31:0]   xfer_addr_o;
  logic [15:0]   xfer_count_o;
  logic [1:0]    xfer_size_o;
  logic          xfer_done_i, xfer_err_i;
  logic          irq_o, idle_o;

  bd_ring_walker #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_ptr_i(base_ptr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o),
    .xfer_count_o(xfer_count_o), .xfer_size_o(xfer_size_o),
    .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i),
    .irq_o(irq_o), .idle_o(idle_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec, n_bad, irq_cnt, lat;
  logic inj_err;
  logic [31:0] dmem [0:255];

  typedef struct packed {
    logic [31:0] a;
    logic [15:0] c;
    logic [1:0]  s;
  } xitem_t;
  xitem_t expq[$];

  // descriptor RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) dmem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= dmem[mem_addr_o];
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // mover stub and scoreboard monitor
  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (xfer_done_i) begin
      xfer_done_i = 1'b0;
      xfer_err_i  = 1'b0;
    end else if (xfer_req_o) begin
      if (lat == 0) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected transfer", xfer_addr_o, 32'h0);
        end else begin
          xitem_t e;
          e = expq.pop_front();
          check(xfer_addr_o == e.a, "R3 address", xfer_addr_o, e.a);
          check(xfer_count_o == e.c, "R3 count", 32'(xfer_count_o), 32'(e.c));
          check(xfer_size_o == e.s, "R3 size", 32'(xfer_size_o), 32'(e.s));
        end
      end
      lat++;
      if (lat == 3) begin
        xfer_done_i = 1'b1;
        xfer_err_i  = inj_err;
        lat = 0;
      end
    end
  end

  function automatic logic [31:0] w0(input logic [7:0] cmd, input logic [7:0] st, input logic [15:0] cnt);
    return {cmd, st, cnt};
  endfunction

  task automatic put_desc(input int at, input logic [7:0] cmd, input logic [7:0] st,
                          input logic [15:0] cnt, input logic [31:0] a);
    dmem[at]   = w0(cmd, st, cnt);
    dmem[at+1] = a;
    dmem[at+2] = 32'h0;
  endtask

  task automatic expect_xfer(input logic [31:0] a, input logic [15:0] c, input logic [1:0] s);
    xitem_t e;
    e.a = a; e.c = c; e.s = s;
    expq.push_back(e);
  endtask

  task automatic pulse_start(input logic [AW-1:0] b);
    @(negedge clk);
    start_i = 1'b1; base_ptr_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int guard;
    guard = 0;
    while (!idle_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(idle_o, tag, 32'(idle_o), 32'h1);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    n_vec = 0; n_bad = 0; irq_cnt = 0; lat = 0; inj_err = 1'b0;
    start_i = 1'b0; base_ptr_i = '0; xfer_done_i = 1'b0; xfer_err_i = 1'b0;
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(idle_o, "R1 idle after reset", 32'(idle_o), 32'h1);
    check(!xfer_req_o && !mem_req_o, "R1 no request after reset", 32'(xfer_req_o), 32'h0);
    check(!irq_o, "R1 no irq after reset", 32'(irq_o), 32'h0);

    // R2 R3 R5 R6 R8: three widths, wrap back to base, decoy after ring
    put_desc(4,  8'd0, 8'h0D, 16'd16, 32'h100);
    put_desc(7,  8'd2, 8'h0D, 16'd6,  32'h202);
    put_desc(10, 8'd1, 8'h0F, 16'd3,  32'h301);
    put_desc(13, 8'd1, 8'h01, 16'd1,  32'h5);
    expect_xfer(32'h100, 16'd16, 2'd2);
    expect_xfer(32'h202, 16'd6,  2'd1);
    expect_xfer(32'h301, 16'd3,  2'd0);
    irq_cnt = 0;
    pulse_start(8'd4);
    check(!idle_o, "R2 walk started", 32'(idle_o), 32'h0);
    wait_idle("R4 idle after ownership stop at base");
    check(expq.size() == 0, "R6 all ring transfers seen", 32'(expq.size()), 32'h0);
    check(dmem[4]  == w0(8'd0, 8'h0C, 16'd16), "R5 writeback d0", dmem[4],  w0(8'd0, 8'h0C, 16'd16));
    check(dmem[7]  == w0(8'd2, 8'h0C, 16'd6),  "R5 writeback d1", dmem[7],  w0(8'd2, 8'h0C, 16'd6));
    check(dmem[10] == w0(8'd1, 8'h0E, 16'd3),  "R5 writeback d2", dmem[10], w0(8'd1, 8'h0E, 16'd3));
    check(dmem[13] == w0(8'd1, 8'h01, 16'd1),  "R6 decoy after ring untouched", dmem[13], w0(8'd1, 8'h01, 16'd1));
    check(irq_cnt == 3, "R8 one irq per flagged descriptor", 32'(irq_cnt), 32'd3);

    // R7: continue clear stops after current descriptor; R8 no irq without flag
    put_desc(20, 8'd0, 8'h01, 16'd8, 32'h40);
    put_desc(23, 8'd1, 8'h05, 16'd2, 32'h41);
    expect_xfer(32'h40, 16'd8, 2'd2);
    irq_cnt = 0;
    pulse_start(8'd20);
    wait_idle("R7 idle after no-continue");
    check(expq.size() == 0, "R7 single transfer", 32'(expq.size()), 32'h0);
    check(dmem[20] == w0(8'd0, 8'h00, 16'd8), "R7 writeback", dmem[20], w0(8'd0, 8'h00, 16'd8));
    check(dmem[23] == w0(8'd1, 8'h05, 16'd2), "R7 next descriptor untouched", dmem[23], w0(8'd1, 8'h05, 16'd2));
    check(irq_cnt == 0, "R8 no irq without flag", 32'(irq_cnt), 32'd0);

    // R9 R10: mover error, misaligned word, odd half-word address, unknown command
    put_desc(30, 8'd0, 8'h0D, 16'd8, 32'h80);
    put_desc(33, 8'd0, 8'h05, 16'd6, 32'h100);
    put_desc(36, 8'd2, 8'h05, 16'd4, 32'h101);
    put_desc(39, 8'd3, 8'h09, 16'd4, 32'h0);
    expect_xfer(32'h80, 16'd8, 2'd2);
    irq_cnt = 0;
    inj_err = 1'b1;
    pulse_start(8'd30);
    wait_idle("R10 idle after error ring");
    inj_err = 1'b0;
    check(expq.size() == 0, "R10 no transfer for bad descriptors", 32'(expq.size()), 32'h0);
    check(dmem[30] == w0(8'd0, 8'h1C, 16'd8), "R9 mover error flagged", dmem[30], w0(8'd0, 8'h1C, 16'd8));
    check(dmem[33] == w0(8'd0, 8'h14, 16'd6), "R10 misaligned word count", dmem[33], w0(8'd0, 8'h14, 16'd6));
    check(dmem[36] == w0(8'd2, 8'h14, 16'd4), "R10 odd half-word address", dmem[36], w0(8'd2, 8'h14, 16'd4));
    check(dmem[39] == w0(8'd3, 8'h18, 16'd4), "R10 unknown command", dmem[39], w0(8'd3, 8'h18, 16'd4));
    check(irq_cnt == 2, "R8 irq for error descriptors", 32'(irq_cnt), 32'd2);

    // R4: start on an unowned descriptor
    dmem[60] = w0(8'd0, 8'h04, 16'd4);
    dmem[61] = 32'h0;
    pulse_start(8'd60);
    wait_idle("R4 idle on unowned start");
    check(dmem[60] == w0(8'd0, 8'h04, 16'd4), "R4 unowned descriptor not written", dmem[60], w0(8'd0, 8'h04, 16'd4));

    // R11: second start while busy is ignored
    put_desc(50, 8'd1, 8'h01, 16'd2, 32'h11);
    put_desc(4,  8'd1, 8'h01, 16'd1, 32'h77);
    expect_xfer(32'h11, 16'd2, 2'd0);
    pulse_start(8'd50);
    while (!xfer_req_o) @(negedge clk);
    start_i = 1'b1; base_ptr_i = 8'd4;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle("R11 idle after busy start");
    check(expq.size() == 0, "R11 only the first walk ran", 32'(expq.size()), 32'h0);
    check(dmem[50] == w0(8'd1, 8'h00, 16'd2), "R11 first walk written back", dmem[50], w0(8'd1, 8'h00, 16'd2));
    check(dmem[4] == w0(8'd1, 8'h01, 16'd1), "R11 ignored base untouched", dmem[4], w0(8'd1, 8'h01, 16'd1));

    finish_up();
  end
endmodule